// File: doc/BRIEF.md
# Dual-Buffer Sequential Address Pointer Controller

This block produces the address for a word-wide memory accessed in sequence, 8K words of 16 bits. Software places two buffers anywhere in that space by giving each one a first address and a last address. While the active-low count enable is low, each clock edge moves the pointer forward by one. When the pointer lands on a buffer's last address, the next edge applies that buffer's own end policy. The pointer can jump to the first address of the other buffer, freeze, carry on, or carry on without lowering the buffer's output flag.

Each buffer has a sticky status flag that records that its end was reached. Software clears a flag by writing a 0 to its bit. The active-low end-of-buffer outputs follow these flags unless the buffer is in masked mode. A frozen pointer raises a write-inhibit output. The pointer starts moving again after a release write, a pointer load, or a jump-to-buffer command. The command port writes and reads the setup registers and issues the pointer commands. The memory array sits outside this block.

Top module: `seq_ptr_ctrl`

## Requirements
- R1: After a synchronous reset (rst_n low at an edge), the pointer is 0, wr_inhibit is 0 and both eob outputs are 1. The reset register values read back as follows: buffer 1 first address 0xE000 and last address 0xEFFF, buffer 2 first address 0xF000 and last address 0xFFFF, policy register 0xFFFA (both buffers linear), status register 0xFFFC.
- R2: When the pointer is not frozen, no command loads it and no end is hit, an edge with cnt_en_n low adds 1 to the pointer, wrapping from 8191 to 0. An edge with cnt_en_n high leaves the pointer unchanged.
- R3: Commands are taken on an edge with cmd_valid high. They are selected by cmd_op: 1 loads the pointer from cmd_wdata[12:0], 2 loads the first address of buffer 1, 3 loads the first address of buffer 2, 4/5 write the first/last address of buffer 1, 6/7 write the first/last address of buffer 2, 8 writes the policy register and 9 writes the status register. cmd_rdata follows cmd_op combinationally, and op 1 reads the pointer.
- R4: Policy code 00 (chain) is set in bits [1:0] for buffer 1 and bits [3:2] for buffer 2. In chain mode, a counting edge with the pointer on that buffer's last address loads the first address of the other buffer. The same edge sets the buffer's status flag, so its eob output goes low after that edge.
- R5: If both buffers are in chain mode and the pointer is on both last addresses, the pointer goes to the first address of buffer 1.
- R6: Policy code 01 (stop): any edge with the pointer on the last address freezes the pointer and sets the flag. The frozen pointer is last+1 if cnt_en_n was low on that edge, and the last address otherwise. While frozen, wr_inhibit is 1 and counting has no effect.
- R7: A policy write with cmd_wdata[4]=0 arms a release for the next edge only. If cnt_en_n is low on that edge, the pointer resumes with +1 and wr_inhibit drops. If cnt_en_n is high, the pointer stays frozen.
- R8: Commands 1, 2 and 3 unfreeze the pointer on the edge that loads it.
- R9: Policy code 10 (linear): reaching the last address sets the flag, lowers the eob output, and the pointer keeps counting.
- R10: Policy code 11 (mask): reaching the last address sets the status bit, but the eob output stays 1. The pointer keeps counting.
- R11: Status bit 0 belongs to buffer 1 and bit 1 to buffer 2. On a status write, a 0 clears the bit and a 1 leaves it unchanged. The two bits are written independently. A cleared flag raises its eob output after the write edge.
- R12: Read bits not used by a register return 1. A policy read returns 1 in bit 4. cmd_op values 0 and 10 to 15 read 0xFFFF and write nothing.
- R13: When both last addresses are equal, both flags are set on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en_n | input | 1 | Active-low count enable |
| cmd_valid | input | 1 | Execute cmd_op on this edge |
| cmd_op | input | 4 | Command / register select |
| cmd_wdata | input | 16 | Write data or load address |
| cmd_rdata | output | 16 | Read data for the selected register |
| ptr | output | 13 | Current sequential address |
| eob1_n | output | 1 | Buffer 1 end reached, active low |
| eob2_n | output | 1 | Buffer 2 end reached, active low |
| wr_inhibit | output | 1 | Pointer frozen, sequential writes blocked |

## Verification
A wrong freeze state shows at once: wr_inhibit is wrong one edge after the last address is met, and the next counting edge leaves the pointer one address off. A lost or stuck release pending bit shows on the first counting edge after a release write, either as a pointer that stays put or as one that moves with cnt_en_n high. A status flag that is wrong shows on its eob output in the cycle after the edge. It also shows on a status read through cmd_rdata, which keeps masked flags visible.

// File: rtl/seq_ptr_pkg.sv
// Package: shared encodings for the dual-buffer sequential pointer.
// Assumes: exactly two buffers; command codes are fixed by this package.
package seq_ptr_pkg;

    localparam int NBUF = 2;

    typedef enum logic [1:0] {
        EOB_CHAIN  = 2'b00,
        EOB_STOP   = 2'b01,
        EOB_LINEAR = 2'b10,
        EOB_MASK   = 2'b11
    } eob_mode_e;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_LOAD  = 4'd1,
        OP_GO1   = 4'd2,
        OP_GO2   = 4'd3,
        OP_S1    = 4'd4,
        OP_E1    = 4'd5,
        OP_S2    = 4'd6,
        OP_E2    = 4'd7,
        OP_FLOW  = 4'd8,
        OP_FLAG  = 4'd9
    } cmd_op_e;

endpackage

// File: rtl/spc_regs.sv
// Module: spc_regs
// Holds the buffer address registers, per-buffer end policy and sticky
// status flags; produces read data and the active-low end outputs.
// Assumes: hit[] is already gated off while the pointer is frozen.
module spc_regs
    import seq_ptr_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cmd_valid,
    input  logic [3:0]                   cmd_op,
    input  logic [DATA_W-1:0]            cmd_wdata,
    input  logic [NBUF-1:0]              hit,
    input  logic [ADDR_W-1:0]            ptr,
    output logic [NBUF-1:0][ADDR_W-1:0]  start_q,
    output logic [NBUF-1:0][ADDR_W-1:0]  end_q,
    output logic [NBUF-1:0][1:0]         mode_q,
    output logic [NBUF-1:0]              flag_q,
    output logic [NBUF-1:0]              eob_n,
    output logic                         rel_req,
    output logic [DATA_W-1:0]            rdata
);

    localparam int FILL_W = DATA_W - ADDR_W;
    localparam logic [ADDR_W-1:0] HALF = ADDR_W'(1) << (ADDR_W - 1);
    localparam logic [3:0] FLOW_RST = {EOB_LINEAR, EOB_LINEAR};

    logic wr_flow;
    logic wr_flag;
    logic unused_hi;

    assign wr_flow   = cmd_valid && (cmd_op == OP_FLOW);
    assign wr_flag   = cmd_valid && (cmd_op == OP_FLAG);
    assign rel_req   = wr_flow && !cmd_wdata[4];
    assign unused_hi = ^cmd_wdata[DATA_W-1:ADDR_W];

    for (genvar b = 0; b < NBUF; b++) begin : g_buf
        localparam logic [3:0] OP_START = 4'(OP_S1) + 4'(2 * b);
        localparam logic [3:0] OP_END   = 4'(OP_E1) + 4'(2 * b);
        localparam logic [ADDR_W-1:0] START_RST = (b == 0) ? '0 : HALF;
        localparam logic [ADDR_W-1:0] END_RST   = (b == 0) ? HALF - 1'b1 : '1;

        // Address registers of this buffer, written by their own command.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                start_q[b] <= START_RST;
                end_q[b]   <= END_RST;
            end else if (cmd_valid) begin
                if (cmd_op == OP_START) start_q[b] <= cmd_wdata[ADDR_W-1:0];
                if (cmd_op == OP_END)   end_q[b]   <= cmd_wdata[ADDR_W-1:0];
            end
        end

        // End policy field of this buffer.
        always_ff @(posedge clk) begin
            if (!rst_n)       mode_q[b] <= FLOW_RST[2*b +: 2];
            else if (wr_flow) mode_q[b] <= cmd_wdata[2*b +: 2];
        end

        // Sticky flag: set by a hit, cleared by a written 0; a hit wins.
        always_ff @(posedge clk) begin
            if (!rst_n)                      flag_q[b] <= 1'b0;
            else if (hit[b])                 flag_q[b] <= 1'b1;
            else if (wr_flag && !cmd_wdata[b]) flag_q[b] <= 1'b0;
        end

        // Output follows the flag unless this buffer is masked.
        assign eob_n[b] = !(flag_q[b] && (mode_q[b] != EOB_MASK));
    end

    // Read mux keyed by the command code; unused bits read as ones.
    always_comb begin
        rdata = '1;
        case (cmd_op)
            OP_LOAD: rdata = {{FILL_W{1'b1}}, ptr};
            OP_S1:   rdata = {{FILL_W{1'b1}}, start_q[0]};
            OP_E1:   rdata = {{FILL_W{1'b1}}, end_q[0]};
            OP_S2:   rdata = {{FILL_W{1'b1}}, start_q[1]};
            OP_E2:   rdata = {{FILL_W{1'b1}}, end_q[1]};
            OP_FLOW: rdata = {{(DATA_W-5){1'b1}}, 1'b1, mode_q[1], mode_q[0]};
            OP_FLAG: rdata = {{(DATA_W-2){1'b1}}, flag_q[1], flag_q[0]};
            default: rdata = '1;
        endcase
    end

endmodule

// File: rtl/spc_end_detect.sv
// Module: spc_end_detect
// Compares the pointer with each buffer's last address and turns the
// matches into stop and chain decisions using each buffer's policy.
// Assumes: no match is reported while the pointer is frozen.
module spc_end_detect
    import seq_ptr_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic [ADDR_W-1:0]            ptr,
    input  logic                         halted,
    input  logic [NBUF-1:0][ADDR_W-1:0]  start_q,
    input  logic [NBUF-1:0][ADDR_W-1:0]  end_q,
    input  logic [NBUF-1:0][1:0]         mode_q,
    output logic [NBUF-1:0]              hit,
    output logic                         stop_hit,
    output logic                         chain_go,
    output logic [ADDR_W-1:0]            chain_tgt
);

    logic [NBUF-1:0] stop_b;
    logic [NBUF-1:0] chain_b;

    for (genvar b = 0; b < NBUF; b++) begin : g_cmp
        // Per-buffer end match and its policy split.
        assign hit[b]     = (ptr == end_q[b]) && !halted;
        assign stop_b[b]  = hit[b] && (mode_q[b] == EOB_STOP);
        assign chain_b[b] = hit[b] && (mode_q[b] == EOB_CHAIN);
    end

    assign stop_hit = |stop_b;
    assign chain_go = |chain_b;
    // A buffer-2 chain (alone or together with buffer 1) goes to buffer 1.
    assign chain_tgt = chain_b[1] ? start_q[0] : start_q[1];

endmodule

// File: rtl/spc_pointer.sv
// Module: spc_pointer
// Pointer register with the frozen state and the one-edge release pending.
// Assumes: ld_en has priority over all counting and release activity.
module spc_pointer #(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_val,
    input  logic              stop_hit,
    input  logic              chain_go,
    input  logic [ADDR_W-1:0] chain_tgt,
    input  logic              rel_req,
    output logic [ADDR_W-1:0] ptr,
    output logic              halted,
    output logic              rel_pend
);

    // Pointer advance, freeze and release sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr      <= '0;
            halted   <= 1'b0;
            rel_pend <= 1'b0;
        end else if (ld_en) begin
            ptr      <= ld_val;
            halted   <= 1'b0;
            rel_pend <= 1'b0;
        end else begin
            rel_pend <= rel_req;
            if (halted) begin
                if (rel_pend && cnt) begin
                    halted <= 1'b0;
                    ptr    <= ptr + 1'b1;
                end
            end else if (stop_hit) begin
                halted <= 1'b1;
                if (cnt) ptr <= ptr + 1'b1;
            end else if (cnt) begin
                ptr <= chain_go ? chain_tgt : ptr + 1'b1;
            end
        end
    end

endmodule

// File: rtl/seq_ptr_ctrl.sv
// Module: seq_ptr_ctrl (top)
// Sequential address pointer serving two software-placed buffers, each
// with its own end policy; decodes load commands and wires the parts.
// Assumes: rst_n is synchronous; cmd_op is stable while cmd_valid is high.
module seq_ptr_ctrl
    import seq_ptr_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en_n,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_op,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic [DATA_W-1:0] cmd_rdata,
    output logic [ADDR_W-1:0] ptr,
    output logic              eob1_n,
    output logic              eob2_n,
    output logic              wr_inhibit
);

    logic [NBUF-1:0][ADDR_W-1:0] start_q;
    logic [NBUF-1:0][ADDR_W-1:0] end_q;
    logic [NBUF-1:0][1:0]        buf_mode;
    logic [NBUF-1:0]             flag_q;
    logic [NBUF-1:0]             eob_n;
    logic [NBUF-1:0]             hit;
    logic                        stop_hit;
    logic                        chain_go;
    logic [ADDR_W-1:0]           chain_tgt;
    logic                        rel_req;
    logic                        rel_pend;
    logic                        halted;
    logic                        ld_en;
    logic [ADDR_W-1:0]           ld_val;

    // Load command decode and its address source.
    always_comb begin
        ld_en  = 1'b0;
        ld_val = cmd_wdata[ADDR_W-1:0];
        if (cmd_valid) begin
            case (cmd_op)
                OP_LOAD: ld_en = 1'b1;
                OP_GO1:  begin ld_en = 1'b1; ld_val = start_q[0]; end
                OP_GO2:  begin ld_en = 1'b1; ld_val = start_q[1]; end
                default: ld_en = 1'b0;
            endcase
        end
    end

    spc_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_wdata(cmd_wdata), .hit(hit), .ptr(ptr), .start_q(start_q),
        .end_q(end_q), .mode_q(buf_mode), .flag_q(flag_q), .eob_n(eob_n),
        .rel_req(rel_req), .rdata(cmd_rdata)
    );

    spc_end_detect #(.ADDR_W(ADDR_W)) u_det (
        .ptr(ptr), .halted(halted), .start_q(start_q), .end_q(end_q),
        .mode_q(buf_mode), .hit(hit), .stop_hit(stop_hit),
        .chain_go(chain_go), .chain_tgt(chain_tgt)
    );

    spc_pointer #(.ADDR_W(ADDR_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .cnt(!cnt_en_n), .ld_en(ld_en),
        .ld_val(ld_val), .stop_hit(stop_hit), .chain_go(chain_go),
        .chain_tgt(chain_tgt), .rel_req(rel_req), .ptr(ptr),
        .halted(halted), .rel_pend(rel_pend)
    );

    assign eob1_n     = eob_n[0];
    assign eob2_n     = eob_n[1];
    assign wr_inhibit = halted;

endmodule

// File: rtl/spc_checker.sv
// Module: spc_checker
// Temporal properties of the pointer controller, bound into the top.
// Assumes: connected to the top's ports plus its decode/detect nets.
module spc_checker
    import seq_ptr_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cnt_en_n,
    input logic              cmd_valid,
    input logic [3:0]        cmd_op,
    input logic [DATA_W-1:0] cmd_wdata,
    input logic [ADDR_W-1:0] ptr,
    input logic              eob1_n,
    input logic              eob2_n,
    input logic              wr_inhibit,
    input logic [3:0]        buf_mode,
    input logic [1:0]        hit,
    input logic              stop_hit,
    input logic              chain_go,
    input logic              rel_pend,
    input logic              ld_en,
    input logic [ADDR_W-1:0] ld_val
);

    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_inhibit && !cnt_en_n && !ld_en && !stop_hit && !chain_go)
        |=> (ptr == $past(ptr) + 1'b1));

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_inhibit && cnt_en_n && !ld_en && !stop_hit) |=> $stable(ptr));

    a_r6_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_inhibit && !ld_en && !rel_pend) |=> ($stable(ptr) && wr_inhibit));

    a_r7_release_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_inhibit && rel_pend && !cnt_en_n && !ld_en)
        |=> (!wr_inhibit && ptr == $past(ptr) + 1'b1));

    a_r8_load_release: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (!wr_inhibit && ptr == $past(ld_val)));

    a_r3_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_LOAD) |=> (ptr == $past(cmd_wdata[ADDR_W-1:0])));

    a_r10_mask_quiet1: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_mode[1:0] == EOB_MASK) |-> eob1_n);

    a_r10_mask_quiet2: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_mode[3:2] == EOB_MASK) |-> eob2_n);

    a_r11_clear1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_FLAG && !cmd_wdata[0] && !hit[0]) |=> eob1_n);

    a_r11_clear2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_FLAG && !cmd_wdata[1] && !hit[1]) |=> eob2_n);

endmodule

bind seq_ptr_ctrl spc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cnt_en_n(cnt_en_n), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_wdata(cmd_wdata), .ptr(ptr), .eob1_n(eob1_n),
    .eob2_n(eob2_n), .wr_inhibit(wr_inhibit), .buf_mode(buf_mode),
    .hit(hit), .stop_hit(stop_hit), .chain_go(chain_go),
    .rel_pend(rel_pend), .ld_en(ld_en), .ld_val(ld_val)
);

// File: tb/tb_seq_ptr_ctrl.sv
module tb_seq_ptr_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en_n = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_op = 4'd0;
    logic [15:0] cmd_wdata = 16'd0;
    logic [15:0] cmd_rdata;
    logic [12:0] ptr;
    logic        eob1_n, eob2_n, wr_inhibit;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    // Row: {op, wdata, valid, cnt_en_n, exp ptr, exp eob1_n, exp eob2_n, exp inhibit}
    localparam logic [37:0] VEC [NVEC] = '{
        {4'd4, 16'd10,     1'b1, 1'b1, 13'd0,  1'b1, 1'b1, 1'b0},
        {4'd5, 16'd12,     1'b1, 1'b1, 13'd0,  1'b1, 1'b1, 1'b0},
        {4'd6, 16'd20,     1'b1, 1'b1, 13'd0,  1'b1, 1'b1, 1'b0},
        {4'd7, 16'd21,     1'b1, 1'b1, 13'd0,  1'b1, 1'b1, 1'b0},
        {4'd8, 16'h0010,   1'b1, 1'b1, 13'd0,  1'b1, 1'b1, 1'b0},
        {4'd2, 16'd0,      1'b1, 1'b1, 13'd10, 1'b1, 1'b1, 1'b0},
        {4'd0, 16'd0,      1'b0, 1'b0, 13'd11, 1'b1, 1'b1, 1'b0},
        {4'd0, 16'd0,      1'b0, 1'b0, 13'd12, 1'b1, 1'b1, 1'b0},
        {4'd0, 16'd0,      1'b0, 1'b0, 13'd20, 1'b0, 1'b1, 1'b0},
        {4'd0, 16'd0,      1'b0, 1'b0, 13'd21, 1'b0, 1'b1, 1'b0},
        {4'd0, 16'd0,      1'b0, 1'b0, 13'd10, 1'b0, 1'b0, 1'b0},
        {4'd9, 16'hFFFE,   1'b1, 1'b1, 13'd10, 1'b1, 1'b0, 1'b0},
        {4'd9, 16'hFFFD,   1'b1, 1'b1, 13'd10, 1'b1, 1'b1, 1'b0},
        {4'd0, 16'd0,      1'b0, 1'b1, 13'd10, 1'b1, 1'b1, 1'b0}
    };

    seq_ptr_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cnt_en_n(cnt_en_n), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
        .ptr(ptr), .eob1_n(eob1_n), .eob2_n(eob2_n), .wr_inhibit(wr_inhibit)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Drive one edge from a falling edge, return at the next falling edge.
    task automatic step(input logic [3:0] op, input logic [15:0] wd,
                        input logic v, input logic cn);
        cmd_op = op; cmd_wdata = wd; cmd_valid = v; cnt_en_n = cn;
        @(posedge clk);
        @(negedge clk);
        cmd_op = 4'd0; cmd_wdata = 16'd0; cmd_valid = 1'b0; cnt_en_n = 1'b1;
    endtask

    task automatic cmd(input logic [3:0] op, input logic [15:0] wd);
        step(op, wd, 1'b1, 1'b1);
    endtask

    task automatic count();
        step(4'd0, 16'd0, 1'b0, 1'b0);
    endtask

    task automatic rd(input string tag, input logic [3:0] op, input logic [15:0] exp);
        cmd_op = op;
        #1;
        chk(tag, {16'd0, cmd_rdata}, {16'd0, exp});
        cmd_op = 4'd0;
    endtask

    task automatic outs(input string tag, input logic [12:0] p, input logic e1,
                        input logic e2, input logic inh);
        chk(tag, {16'd0, ptr, eob1_n, eob2_n, wr_inhibit}, {16'd0, p, e1, e2, inh});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        outs("R1 reset outputs", 13'd0, 1'b1, 1'b1, 1'b0);
        rd("R1 start1", 4'd4, 16'hE000);
        rd("R1 end1",   4'd5, 16'hEFFF);
        rd("R1 start2", 4'd6, 16'hF000);
        rd("R1 end2",   4'd7, 16'hFFFF);
        rd("R1 policy", 4'd8, 16'hFFFA);
        rd("R1 status", 4'd9, 16'hFFFC);

        // Table: setup, chaining (R4), flag clears (R11)
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][37:34], VEC[i][33:18], VEC[i][17], VEC[i][16]);
            outs($sformatf("R4/R11 vector %0d", i), VEC[i][15:3], VEC[i][2], VEC[i][1], VEC[i][0]);
        end

        // R3 load and pointer readback
        cmd(4'd1, 16'd100);
        outs("R3 load", 13'd100, 1'b1, 1'b1, 1'b0);
        rd("R3 read ptr", 4'd1, 16'hE064);

        // R2 wrap and hold
        cmd(4'd1, 16'd8190);
        count();
        outs("R2 to 8191", 13'd8191, 1'b1, 1'b1, 1'b0);
        count();
        outs("R2 wrap", 13'd0, 1'b1, 1'b1, 1'b0);
        step(4'd0, 16'd0, 1'b0, 1'b1);
        outs("R2 hold", 13'd0, 1'b1, 1'b1, 1'b0);

        // R12 readback and reserved codes
        rd("R12 start1", 4'd4, 16'hE00A);
        rd("R12 end1",   4'd5, 16'hE00C);
        rd("R12 start2", 4'd6, 16'hE014);
        rd("R12 end2",   4'd7, 16'hE015);
        rd("R12 policy", 4'd8, 16'hFFF0);
        rd("R12 op10",   4'd10, 16'hFFFF);
        rd("R12 op0",    4'd0, 16'hFFFF);
        cmd(4'd12, 16'd0);
        outs("R12 reserved write", 13'd0, 1'b1, 1'b1, 1'b0);
        rd("R12 end1 kept", 4'd5, 16'hE00C);

        // R6 stop with count, R7 release
        cmd(4'd8, 16'h0011);
        cmd(4'd2, 16'd0);
        count(); count();
        outs("R6 at end", 13'd12, 1'b1, 1'b1, 1'b0);
        count();
        outs("R6 halt end+1", 13'd13, 1'b0, 1'b1, 1'b1);
        count();
        outs("R6 count ignored", 13'd13, 1'b0, 1'b1, 1'b1);
        cmd(4'd8, 16'h0001);
        outs("R7 release armed", 13'd13, 1'b0, 1'b1, 1'b1);
        count();
        outs("R7 resume end+2", 13'd14, 1'b0, 1'b1, 1'b0);

        // R6 stop without count, R7 release lost, R8 command release
        cmd(4'd9, 16'hFFFC);
        cmd(4'd2, 16'd0);
        count(); count();
        step(4'd0, 16'd0, 1'b0, 1'b1);
        outs("R6 halt at end", 13'd12, 1'b0, 1'b1, 1'b1);
        cmd(4'd8, 16'h0001);
        step(4'd0, 16'd0, 1'b0, 1'b1);
        outs("R7 no count keeps stop", 13'd12, 1'b0, 1'b1, 1'b1);
        count();
        outs("R7 release expired", 13'd12, 1'b0, 1'b1, 1'b1);
        cmd(4'd3, 16'd0);
        outs("R8 start2 releases", 13'd20, 1'b0, 1'b1, 1'b0);

        // R9 linear
        cmd(4'd8, 16'h0012);
        cmd(4'd9, 16'hFFFC);
        cmd(4'd2, 16'd0);
        count(); count(); count();
        outs("R9 linear flag", 13'd13, 1'b0, 1'b1, 1'b0);
        count();
        outs("R9 keeps counting", 13'd14, 1'b0, 1'b1, 1'b0);

        // R10 mask
        cmd(4'd8, 16'h0013);
        outs("R10 mask hides flag", 13'd14, 1'b1, 1'b1, 1'b0);
        cmd(4'd9, 16'hFFFC);
        cmd(4'd2, 16'd0);
        count(); count(); count();
        outs("R10 mask passes end", 13'd13, 1'b1, 1'b1, 1'b0);
        rd("R10 status set", 4'd9, 16'hFFFD);

        // R5 and R13 equal ends, both chaining
        cmd(4'd7, 16'd12);
        cmd(4'd8, 16'h0010);
        cmd(4'd9, 16'hFFFC);
        cmd(4'd2, 16'd0);
        count(); count(); count();
        outs("R5/R13 equal ends", 13'd10, 1'b0, 1'b0, 1'b0);
        rd("R13 both flags", 4'd9, 16'hFFFF);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule